// File: doc/BRIEF.md
# Prescaled Reload Timer

A 32-bit down-counting timer configured through a small word-addressed register port. Software programs a reload value, an optional live count and a control word holding an enable, an auto-reload switch and an 8-bit prescale value P. While enabled with a nonzero count, the counter decrements once every P+1 clock cycles.

When the count reaches zero, a sticky status bit is set, and that bit drives the level interrupt output directly. In auto-reload mode the counter restarts from the reload value and keeps running. In one-shot mode it rests at zero and raises no further events. Software acknowledges the event by writing a one to the status bit.

Writes take effect at the clock edge that samples them. Reads are combinational from the address. Any write to the reload, counter or control register restarts the prescaler phase.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, the reload value, counter, control and status are all zero, and the interrupt output is low.
- R2: Register offsets: 0x00 reload value, 0x04 counter, 0x08 control, 0x0C status (bit 0). Control bit 0 is enable, bit 1 is auto-reload, and bits [15:8] hold P. Control reads back only those bits. Any other offset, including a misaligned one, reads zero, and a write to it changes nothing.
- R3: After a write of N to the counter or reload register while enabled, the first decrement lands P+1 cycles after the write edge, and each later decrement follows P+1 cycles after the previous one.
- R4: When the counter steps from 1 to 0, status bit 0 is set, and the interrupt output equals that bit.
- R5: With auto-reload on, the step that would reach zero loads the reload value instead, and counting continues with period N*(P+1).
- R6: With auto-reload off, the counter stays at zero after expiry and raises no further events. A zero counter never decrements, even while enabled.
- R7: A write to the reload register sets both the reload value and the counter.
- R8: A write to the counter register changes only the counter.
- R9: A write that turns enable from 0 to 1 while the counter is zero and auto-reload is set copies the reload value into the counter. With auto-reload clear, the counter stays zero.
- R10: While enable is clear, the counter reads as zero and its held value does not change. Enabling again exposes the held value.
- R11: Writing 1 to status bit 0 clears it and drops the interrupt. Writing 0 leaves it unchanged.
- R12: If an expiry and a status clear land on the same edge, status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for the current address |
| irq | output | 1 | Level interrupt, equal to status bit 0 |

## Verification
The bench sweeps P and the start count and compares the counter value with floor division on every cycle. An off-by-one in the prescaler phase would therefore show up as a value that moves one cycle early or late. Auto-reload runs are followed through two full periods, so a design that dropped to zero or skipped a reload would be seen at the period boundary. Further tests target:
- the enable-edge preload, with and without auto-reload;
- the masked read while disabled, which a leaky design would show as a nonzero value;
- the case where a clear arrives on the same edge as an expiry, where a design with the wrong priority would lose the event;
- unmapped and misaligned writes, which a loose decoder would let corrupt a register.

// File: rtl/prt_pkg.sv
package prt_pkg;
    // word indexes within the register window
    localparam int WORD_LOAD  = 0;
    localparam int WORD_COUNT = 1;
    localparam int WORD_CTRL  = 2;
    localparam int WORD_STAT  = 3;
    // control field positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_AR_BIT  = 1;
    localparam int CTRL_PRE_LSB = 8;
endpackage

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] divide,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (restart || !run) begin
            st_d.phase = '0;
        end else if (st_q.phase == divide) begin
            tick       = 1'b1;
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a tick never arrives while stopped or in a restart cycle
    assert_tick_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart || !run) |-> !tick);
endmodule

// File: rtl/prt_core.sv
module prt_core #(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_count,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wr_value,
    input  logic              new_en,
    input  logic              new_ar,
    input  logic [PRE_W-1:0]  new_pre,
    input  logic              clr_bit,
    input  logic              tick,
    output logic              run,
    output logic              restart,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] count_o,
    output logic              en_o,
    output logic              ar_o,
    output logic [PRE_W-1:0]  pre_o,
    output logic              status_o
);
    typedef struct packed {
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] count;
        logic              en;
        logic              ar;
        logic [PRE_W-1:0]  pre;
        logic              status;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        expire;

    assign run     = st_q.en && (st_q.count != '0);
    assign restart = wr_load || wr_count || wr_ctrl;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (tick) begin
            if (st_q.count == DATA_W'(1)) begin
                expire     = 1'b1;
                st_d.count = st_q.ar ? st_q.load : '0;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
        if (wr_load) begin
            st_d.load  = wr_value;
            st_d.count = wr_value;
        end
        if (wr_count) st_d.count = wr_value;
        if (wr_ctrl) begin
            st_d.en  = new_en;
            st_d.ar  = new_ar;
            st_d.pre = new_pre;
            if (!st_q.en && new_en && new_ar && st_q.count == '0)
                st_d.count = st_q.load;
        end
        st_d.status = (st_q.status && !(wr_stat && clr_bit)) || expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o   = st_q.load;
    assign count_o  = st_q.count;
    assign en_o     = st_q.en;
    assign ar_o     = st_q.ar;
    assign pre_o    = st_q.pre;
    assign status_o = st_q.status;

    assert_load_sets_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (st_q.load == $past(wr_value) && st_q.count == $past(wr_value)));
    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && st_q.count > DATA_W'(1)) |=>
        (st_q.count == $past(st_q.count) || st_q.count == $past(st_q.count) - 1'b1));
    assert_zero_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == '0) |-> !expire);
    assert_expiry_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st_q.status);
    assert_clear_works_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && clr_bit && !expire) |=> !st_q.status);
    assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !restart) |=> $stable(st_q.count));
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    import prt_pkg::*;

    localparam int WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word;
    logic              wr_load, wr_count, wr_ctrl, wr_stat;
    logic              run, restart, tick;
    logic [DATA_W-1:0] load_q, count_q;
    logic              en_q, ar_q, status_q;
    logic [PRE_W-1:0]  pre_q;

    assign aligned  = (addr[1:0] == 2'b00);
    assign word     = addr[ADDR_W-1:2];
    assign wr_load  = wr_en && aligned && (word == WORD_W'(WORD_LOAD));
    assign wr_count = wr_en && aligned && (word == WORD_W'(WORD_COUNT));
    assign wr_ctrl  = wr_en && aligned && (word == WORD_W'(WORD_CTRL));
    assign wr_stat  = wr_en && aligned && (word == WORD_W'(WORD_STAT));

    prt_core #(.DATA_W(DATA_W), .PRE_W(PRE_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_load  (wr_load),
        .wr_count (wr_count),
        .wr_ctrl  (wr_ctrl),
        .wr_stat  (wr_stat),
        .wr_value (wdata),
        .new_en   (wdata[CTRL_EN_BIT]),
        .new_ar   (wdata[CTRL_AR_BIT]),
        .new_pre  (wdata[CTRL_PRE_LSB +: PRE_W]),
        .clr_bit  (wdata[0]),
        .tick     (tick),
        .run      (run),
        .restart  (restart),
        .load_o   (load_q),
        .count_o  (count_q),
        .en_o     (en_q),
        .ar_o     (ar_q),
        .pre_o    (pre_q),
        .status_o (status_q)
    );

    prt_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .divide  (pre_q),
        .tick    (tick)
    );

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (word == WORD_W'(WORD_LOAD)) begin
                rdata = load_q;
            end else if (word == WORD_W'(WORD_COUNT)) begin
                rdata = en_q ? count_q : '0;
            end else if (word == WORD_W'(WORD_CTRL)) begin
                rdata[CTRL_EN_BIT]            = en_q;
                rdata[CTRL_AR_BIT]            = ar_q;
                rdata[CTRL_PRE_LSB +: PRE_W]  = pre_q;
            end else if (word == WORD_W'(WORD_STAT)) begin
                rdata[0] = status_q;
            end
        end
    end

    assign irq = status_q;

    // R2: a write outside the window leaves the reload value untouched
    assert_unmapped_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !aligned) |=> $stable(load_q));
endmodule

// File: tb/test_prescaled_reload_timer.sv
module test_prescaled_reload_timer;
    localparam logic [4:0] A_LOAD = 5'h00;
    localparam logic [4:0] A_CNT  = 5'h04;
    localparam logic [4:0] A_CTRL = 5'h08;
    localparam logic [4:0] A_STAT = 5'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    prescaled_reload_timer i_prescaled_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // called just after a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        chk(rdata, exp, req);
    endtask

    task automatic cleanup();
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'h0);
        wr(A_STAT, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_LOAD, 0, "R1"); rd(A_CTRL, 0, "R1"); rd(A_STAT, 0, "R1");
        chk({31'b0, irq}, 0, "R1");

        // R2 control readback and unmapped / misaligned offsets
        wr(A_LOAD, 32'h55);
        wr(A_CTRL, 32'hFFFF_FFFC);
        rd(A_CTRL, 32'h0000_FF00, "R2");
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h01, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(A_LOAD, 32'h55, "R2"); rd(A_CTRL, 32'h0000_FF00, "R2");
        rd(A_STAT, 0, "R2"); rd(5'h10, 0, "R2"); rd(5'h01, 0, "R2");
        chk({31'b0, irq}, 0, "R2");
        cleanup();

        // R3 R4 R6 one-shot sweep
        for (int p = 0; p < 4; p++) begin
            for (int n = 1; n < 5; n++) begin
                int t;
                cleanup();
                wr(A_CTRL, (p << 8) | 1);
                wr(A_CNT, n);
                t = n * (p + 1);
                for (int j = 0; j <= t + 3; j++) begin
                    rd(A_CNT, (j >= t) ? 0 : n - j / (p + 1), (j > t) ? "R6" : "R3");
                    chk({31'b0, irq}, (j >= t) ? 1 : 0, (j > t) ? "R6" : "R4");
                    @(negedge clk);
                end
            end
        end

        // R5 auto-reload sweep over two periods
        for (int p = 0; p < 3; p++) begin
            for (int l = 1; l < 4; l++) begin
                int t;
                cleanup();
                wr(A_CTRL, (p << 8) | 3);
                wr(A_LOAD, l);
                t = l * (p + 1);
                for (int j = 0; j <= 2 * t + 1; j++) begin
                    rd(A_CNT, l - (j % t) / (p + 1), "R5");
                    chk({31'b0, irq}, (j >= t) ? 1 : 0, "R5");
                    @(negedge clk);
                end
            end
        end

        // R8 counter write leaves reload value; R10 masked read while disabled
        cleanup();
        wr(A_LOAD, 32'h9);
        wr(A_CNT, 32'h7);
        rd(A_LOAD, 32'h9, "R8");
        rd(A_CNT, 0, "R10");
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'h1);
        rd(A_CNT, 32'h7, "R10");

        // R7 reload write also sets the counter
        cleanup();
        wr(A_LOAD, 32'h23);
        wr(A_CTRL, 32'h0000_0501);
        rd(A_CNT, 32'h23, "R7");
        rd(A_LOAD, 32'h23, "R7");

        // R9 enable-edge preload
        cleanup();
        wr(A_CTRL, 32'h0000_0303);
        rd(A_CNT, 32'h23, "R9");
        cleanup();
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_CNT, 0, "R9");
        chk({31'b0, irq}, 0, "R9");

        // R12 expiry on the clear edge; R11 write-one-to-clear
        cleanup();
        wr(A_LOAD, 32'h1);
        wr(A_CTRL, 32'h3);
        @(negedge clk);
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h1, "R12");
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h1, "R11");
        chk({31'b0, irq}, 1, "R11");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h0, "R11");
        chk({31'b0, irq}, 0, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule